// File: doc/BRIEF.md
# Memory-Mapped Stream Port Array

This block is a bus slave with a bank of 2^n stream ports. Each port has an address of its own on the bus. A host master writes 32-bit words to a port's data address, and those words leave the block one at a time on that port's outbound valid/ready stream, in the order they were written. A computation block returns results on the port's inbound valid/ready stream. The host collects them by reading the same data address again and again. The address never advances, so a block transfer aimed at one port address feeds or drains a whole stream word by word.

Each port has a second address, its status address. A read there returns how many words wait in each direction, so software can poll a port before it starts a transfer. Bus cycles follow the classic single-access handshake. An access that cannot complete is stalled rather than refused: a write to a full outbound queue, or a read from an empty inbound queue, holds off the acknowledge until the queue can serve it. Queue depth, port count and word width are parameters.

Top module: `stream_port_array`

## Requirements
- R1: After reset every queue is empty. All `tx_valid` bits are 0, all `rx_ready` bits are 1, `wb_ack_o` is 0, and every status read returns 0.
- R2: A write to word address {0, p} (bit PORT_BITS = 0, low bits = port p) places the word in port p's outbound queue. The oldest queued word is presented on `tx_data` slice p with `tx_valid[p]` high.
- R3: An outbound word leaves only on a clock edge where `tx_valid[p]` and `tx_ready[p]` are both high. While `tx_ready[p]` is low, `tx_valid[p]` and the slice stay unchanged.
- R4: An inbound word enters port p's queue on an edge with `rx_valid[p]` and `rx_ready[p]` both high. `rx_ready[p]` is low exactly when that queue is full, and offered words are not taken then.
- R5: Repeated accesses to one constant data address transfer successive words in first-in first-out order in both directions.
- R6: A write to a full outbound queue keeps `wb_ack_o` low until a word drains. The write then completes and its word is queued behind the others.
- R7: A read from an empty inbound queue keeps `wb_ack_o` low until a word arrives. The read then completes with that word.
- R8: A read of word address {1, p} returns the outbound level of port p in bits 31:16 and the inbound level in bits 15:0. A write to a status address is acknowledged and changes nothing.
- R9: `wb_ack_o` rises on the cycle after an access is accepted and lasts one cycle, even if the strobe stays high.
- R10: If an inbound stream push and a bus pop hit the same queue in the same cycle, its level stays unchanged.
- R11: An access to one port leaves every other port's queues and stream outputs untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | PORT_BITS+1 | Word address: top bit selects status, low bits select port |
| wb_dat_i | input | DW | Write data |
| wb_dat_o | output | DW | Read data, valid with ack |
| wb_ack_o | output | 1 | Access acknowledge |
| tx_valid | output | 2^PORT_BITS | Outbound word available, per port |
| tx_ready | input | 2^PORT_BITS | Outbound sink accepts, per port |
| tx_data | output | 2^PORT_BITS*DW | Outbound words, port p in slice p |
| rx_valid | input | 2^PORT_BITS | Inbound word offered, per port |
| rx_ready | output | 2^PORT_BITS | Inbound queue has space, per port |
| rx_data | input | 2^PORT_BITS*DW | Inbound words, port p in slice p |

## Verification
A corrupted queue pointer or level becomes visible at the ports within one access or one stream transfer. A status read returns the wrong count, words come out of order or duplicated, or `tx_valid`/`rx_ready` disagree with the number of words pushed. Stall logic that is decoded wrongly shows up at once as an acknowledge on a full or empty queue, or as one that never comes after space frees. The bench therefore checks data order, flag levels and status words directly after each stimulus. A port-decode fault shows up as activity on a neighbouring port.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;
  // Level after one cycle with an optional push and pop.
  function automatic logic [15:0] next_level(input logic [15:0] lvl, input logic inc, input logic dec);
    return lvl + {15'd0, inc} - {15'd0, dec};
  endfunction

  // Status word: outbound level high half, inbound level low half.
  function automatic logic [31:0] pack_status(input logic [15:0] out_lvl, input logic [15:0] in_lvl);
    return {out_lvl, in_lvl};
  endfunction
endpackage

// File: rtl/sp_fifo.sv
`timescale 1ns/1ps
module sp_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  import sp_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    store [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] lvl_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == CNT_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = store[rp];
  assign level   = lvl_q;

  always_ff @(posedge clk) begin
    if (push_ok) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      lvl_q <= CNT_W'(next_level(16'(lvl_q), push_ok, pop_ok));
    end
  end
endmodule

// File: rtl/sp_wb_front.sv
`timescale 1ns/1ps
module sp_wb_front #(
  parameter int PORT_BITS = 2,
  parameter int NP        = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc,
  input  logic                 stb,
  input  logic                 we,
  input  logic                 sel_stat,
  input  logic [PORT_BITS-1:0] port,
  input  logic [NP-1:0]        tx_full,
  input  logic [NP-1:0]        rx_empty,
  output logic                 accept,
  output logic [NP-1:0]        acc_push,
  output logic [NP-1:0]        acc_pop,
  output logic                 ack
);
  logic can_go;
  logic [NP-1:0] port_sel;

  assign port_sel = NP'(1) << port;
  assign can_go   = sel_stat || (we ? !tx_full[port] : !rx_empty[port]);
  assign accept   = cyc && stb && !ack && can_go;
  assign acc_push = (accept && we && !sel_stat)  ? port_sel : '0;
  assign acc_pop  = (accept && !we && !sel_stat) ? port_sel : '0;

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= accept;
  end
endmodule

// File: rtl/stream_port_array.sv
`timescale 1ns/1ps
module stream_port_array #(
  parameter int PORT_BITS = 2,
  parameter int DW        = 32,
  parameter int DEPTH     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wb_cyc_i,
  input  logic                          wb_stb_i,
  input  logic                          wb_we_i,
  input  logic [PORT_BITS:0]            wb_adr_i,
  input  logic [DW-1:0]                 wb_dat_i,
  output logic [DW-1:0]                 wb_dat_o,
  output logic                          wb_ack_o,
  output logic [(1<<PORT_BITS)-1:0]     tx_valid,
  input  logic [(1<<PORT_BITS)-1:0]     tx_ready,
  output logic [(1<<PORT_BITS)*DW-1:0]  tx_data,
  input  logic [(1<<PORT_BITS)-1:0]     rx_valid,
  output logic [(1<<PORT_BITS)-1:0]     rx_ready,
  input  logic [(1<<PORT_BITS)*DW-1:0]  rx_data
);
  import sp_pkg::*;
  localparam int NP    = 1 << PORT_BITS;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                 sel_stat;
  logic [PORT_BITS-1:0] port;
  logic                 accept;
  logic [NP-1:0]        acc_push, acc_pop;
  logic [NP-1:0]        tx_full_v, tx_empty_v, rx_full_v, rx_empty_v;
  logic [CNT_W-1:0]     tx_lvl [NP];
  logic [CNT_W-1:0]     rx_lvl [NP];
  logic [DW-1:0]        rx_head [NP];

  assign sel_stat = wb_adr_i[PORT_BITS];
  assign port     = wb_adr_i[PORT_BITS-1:0];

  sp_wb_front #(.PORT_BITS(PORT_BITS), .NP(NP)) u_front (
    .clk(clk), .rst(rst), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
    .sel_stat(sel_stat), .port(port), .tx_full(tx_full_v), .rx_empty(rx_empty_v),
    .accept(accept), .acc_push(acc_push), .acc_pop(acc_pop), .ack(wb_ack_o)
  );

  for (genvar i = 0; i < NP; i++) begin : g_port
    sp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx (
      .clk(clk), .rst(rst), .push(acc_push[i]), .wdata(wb_dat_i),
      .pop(tx_valid[i] && tx_ready[i]), .rdata(tx_data[i*DW +: DW]),
      .level(tx_lvl[i]), .full(tx_full_v[i]), .empty(tx_empty_v[i])
    );
    sp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx (
      .clk(clk), .rst(rst), .push(rx_valid[i]), .wdata(rx_data[i*DW +: DW]),
      .pop(acc_pop[i]), .rdata(rx_head[i]),
      .level(rx_lvl[i]), .full(rx_full_v[i]), .empty(rx_empty_v[i])
    );
    assign tx_valid[i] = !tx_empty_v[i];
    assign rx_ready[i] = !rx_full_v[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_dat_o <= '0;
    end else if (accept && !wb_we_i) begin
      if (sel_stat) wb_dat_o <= DW'(pack_status(16'(tx_lvl[port]), 16'(rx_lvl[port])));
      else          wb_dat_o <= rx_head[port];
    end
  end
endmodule

// File: rtl/sp_port_array_chk.sv
`timescale 1ns/1ps
module sp_port_array_chk #(
  parameter int NP = 4,
  parameter int DW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           cyc,
  input logic           stb,
  input logic           ack,
  input logic [NP-1:0]  acc_push,
  input logic [NP-1:0]  acc_pop,
  input logic [NP-1:0]  tx_full,
  input logic [NP-1:0]  rx_empty,
  input logic [NP-1:0]  tx_valid,
  input logic [NP-1:0]  tx_ready,
  input logic [NP*DW-1:0] tx_data
);
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) ack |=> !ack); // R9
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) $rose(ack) |-> $past(cyc && stb)); // R9
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst) (acc_push & tx_full) == '0); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) (acc_pop & rx_empty) == '0); // R7
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst) $onehot0(acc_push | acc_pop)); // R11

  for (genvar i = 0; i < NP; i++) begin : g_hold
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
      (tx_valid[i] && !tx_ready[i]) |=> (tx_valid[i] && $stable(tx_data[i*DW +: DW]))); // R3
  end
endmodule

bind stream_port_array sp_port_array_chk #(.NP(NP), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cyc(wb_cyc_i), .stb(wb_stb_i), .ack(wb_ack_o),
  .acc_push(acc_push), .acc_pop(acc_pop), .tx_full(tx_full_v), .rx_empty(rx_empty_v),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/tb_stream_port_array.sv
`timescale 1ns/1ps
module tb_stream_port_array;
  localparam int PB = 2;
  localparam int NP = 4;
  localparam int DW = 32;

  logic clk = 0;
  logic rst = 1;
  logic cyc = 0, stb = 0, we = 0;
  logic [PB:0] adr = '0;
  logic [DW-1:0] dat_i = '0;
  logic [DW-1:0] dat_o;
  logic ack;
  logic [NP-1:0] tx_valid, rx_ready;
  logic [NP-1:0] tx_ready = '0, rx_valid = '0;
  logic [NP*DW-1:0] tx_data;
  logic [NP*DW-1:0] rx_data = '0;
  int total = 0, bad = 0;
  logic [DW-1:0] got;
  logic seen;

  always #2.5 clk = ~clk;

  stream_port_array #(.PORT_BITS(PB), .DW(DW), .DEPTH(4)) dut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat_i), .wb_dat_o(dat_o), .wb_ack_o(ack),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] txd(input int p);
    return tx_data[p*DW +: DW];
  endfunction

  task automatic wb_go(input logic w, input logic st, input int p, input logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = {st, 2'(p)}; dat_i = d;
  endtask

  task automatic wait_ack(input int maxc);
    seen = 0;
    for (int i = 0; i < maxc && !seen; i++) begin
      @(posedge clk); #1;
      if (ack) begin seen = 1; got = dat_o; end
    end
    if (seen) begin cyc = 0; stb = 0; end
  endtask

  task automatic wr(input int p, input logic [31:0] d, input string req);
    wb_go(1, 0, p, d); wait_ack(20);
    chk(seen, req, {31'd0, seen}, 1);
  endtask

  task automatic rd(input logic st, input int p, input string req);
    wb_go(0, st, p, 0); wait_ack(20);
    chk(seen, req, {31'd0, seen}, 1);
  endtask

  task automatic rx_send(input int p, input logic [31:0] d);
    @(negedge clk);
    rx_valid[p] = 1; rx_data[p*DW +: DW] = d;
    @(negedge clk);
    rx_valid[p] = 0;
  endtask

  task automatic drain(input int p, input int n, input logic [31:0] e [4], input string req);
    @(negedge clk); tx_ready[p] = 1;
    for (int k = 0; k < n; k++) begin
      chk(tx_valid[p] && txd(p) == e[k], req, txd(p), e[k]);
      @(posedge clk); #1;
    end
    chk(!tx_valid[p], req, {31'd0, tx_valid[p]}, 0);
    @(negedge clk); tx_ready[p] = 0;
  endtask

  task automatic t_reset;
    chk(tx_valid == '0, "R1 tx_valid", {28'd0, tx_valid}, 0);
    chk(rx_ready == '1, "R1 rx_ready", {28'd0, rx_ready}, 32'hF);
    chk(!ack, "R1 ack", {31'd0, ack}, 0);
    rd(1, 3, "R1 status read");
    chk(got == 0, "R1 status", got, 0);
  endtask

  task automatic t_tx_order;
    logic [31:0] e [4] = '{32'hA0, 32'hA1, 32'hA2, 32'h0};
    wr(2, e[0], "R2"); wr(2, e[1], "R5"); wr(2, e[2], "R5");
    chk(tx_valid == 4'b0100 && txd(2) == e[0], "R2 head", {28'd0, tx_valid}, 32'h4);
    chk(tx_valid[0] == 0, "R11 port0 idle", {31'd0, tx_valid[0]}, 0);
    rd(1, 2, "R8 status read");
    chk(got == 32'h0003_0000, "R8 tx level", got, 32'h0003_0000);
    repeat (3) @(posedge clk); #1;
    chk(tx_valid[2] && txd(2) == e[0], "R3 hold", txd(2), e[0]);
    drain(2, 3, e, "R3 R5 drain");
  endtask

  task automatic t_full_stall;
    logic [31:0] e [4] = '{32'hB1, 32'hB2, 32'hB3, 32'hB4};
    wr(1, 32'hB0, "R6 fill"); wr(1, e[0], "R6 fill"); wr(1, e[1], "R6 fill"); wr(1, e[2], "R6 fill");
    wb_go(1, 0, 1, e[3]); wait_ack(6);
    chk(!seen, "R6 stall", {31'd0, seen}, 0);
    @(negedge clk); tx_ready[1] = 1;
    @(negedge clk); tx_ready[1] = 0;
    wait_ack(6);
    chk(seen, "R6 release", {31'd0, seen}, 1);
    drain(1, 4, e, "R6 order");
  endtask

  task automatic t_rx_order;
    rx_send(3, 32'hC0); rx_send(3, 32'hC1); rx_send(3, 32'hC2);
    rd(1, 3, "R8 status read");
    chk(got == 32'h0000_0003, "R8 rx level", got, 3);
    rd(0, 3, "R4"); chk(got == 32'hC0, "R4 word0", got, 32'hC0);
    rd(0, 3, "R5"); chk(got == 32'hC1, "R5 word1", got, 32'hC1);
    rd(0, 3, "R5"); chk(got == 32'hC2, "R5 word2", got, 32'hC2);
  endtask

  task automatic t_rx_full;
    for (int k = 0; k < 4; k++) rx_send(0, 32'hD0 + k);
    chk(rx_ready[0] == 0, "R4 full flag", {31'd0, rx_ready[0]}, 0);
    rx_send(0, 32'hDEAD);
    for (int k = 0; k < 4; k++) begin
      rd(0, 0, "R4");
      chk(got == 32'hD0 + k, "R4 full order", got, 32'hD0 + k);
    end
    rd(1, 0, "R4 status read");
    chk(got == 0, "R4 extra not taken", got, 0);
  endtask

  task automatic t_empty_stall;
    wb_go(0, 0, 2, 0); wait_ack(6);
    chk(!seen, "R7 stall", {31'd0, seen}, 0);
    rx_send(2, 32'hE5);
    wait_ack(6);
    chk(seen && got == 32'hE5, "R7 release", got, 32'hE5);
  endtask

  task automatic t_same_cycle;
    rx_send(1, 32'hF0); rx_send(1, 32'hF1);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = {1'b0, 2'd1};
    rx_valid[1] = 1; rx_data[DW +: DW] = 32'hF2;
    @(posedge clk); #1;
    rx_valid[1] = 0;
    chk(ack && dat_o == 32'hF0, "R10 pop", dat_o, 32'hF0);
    cyc = 0; stb = 0;
    rd(1, 1, "R10 status read");
    chk(got == 32'h0000_0002, "R10 level", got, 2);
    rd(0, 1, "R10"); chk(got == 32'hF1, "R10 next", got, 32'hF1);
    rd(0, 1, "R10"); chk(got == 32'hF2, "R10 last", got, 32'hF2);
  endtask

  task automatic t_status_write;
    wr(0, 32'h1111, "R8 queue");
    wb_go(1, 1, 0, 32'hFFFF_FFFF); wait_ack(20);
    chk(seen, "R8 status write ack", {31'd0, seen}, 1);
    rd(1, 0, "R8 status read");
    chk(got == 32'h0001_0000, "R8 write ignored", got, 32'h0001_0000);
    chk(tx_valid == 4'b0001 && txd(0) == 32'h1111, "R11 only port0", txd(0), 32'h1111);
    @(negedge clk); tx_ready[0] = 1;
    @(negedge clk); tx_ready[0] = 0;
  endtask

  task automatic t_ack_pulse;
    wb_go(0, 1, 0, 0);
    @(posedge clk); #1;
    chk(ack, "R9 ack rises", {31'd0, ack}, 1);
    @(posedge clk); #1;
    chk(!ack, "R9 ack one cycle", {31'd0, ack}, 0);
    cyc = 0; stb = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_tx_order();
    t_full_stall();
    t_rx_order();
    t_rx_full();
    t_empty_stall();
    t_same_cycle();
    t_status_write();
    t_ack_pulse();
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule